// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. The capacitor array and the comparator sit outside it. The block puts a trial code on `dac_code` and reads the comparator's decision back on `cmp_in`. It moves only on clock edges where the machine-cycle strobe `mc_stb` is high. Each conversion has three parts: a sample phase of fixed length, one strobe per result bit from the most significant bit down, and a single write-result cycle.

Software uses a small register bus. Writing anything to the low result register starts a conversion. The control register holds the continuous-mode bit, shows the busy flag and holds the interrupt-request flag. The two result registers return the last result. In continuous mode a new conversion begins in the machine cycle right after each write-result cycle, and this repeats until software clears the mode bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write to address 2 (low result register) starts a conversion whatever data it carries. Sampling begins, with `busy_o` and `sample_o` high, at the first strobe edge after the write edge. A second start needs a second write.
- R2: The result is found one bit per strobe, from bit 9 down to bit 0. The bit under test is kept when `cmp_in` is 1, with `cmp_in` meaning the analog input is at or above `dac_code`. For a steady input value V from 0 to 1023, the result equals V.
- R3: Sampling lasts SAMPLE_CYC strobe periods (default 2) and conversion lasts 10. `busy_o` stays high for exactly SAMPLE_CYC+10 strobe periods. `sample_o` is high only during sampling. `busy_o` changes only on strobe edges.
- R4: `busy_o` clears on the strobe edge that enters the write-result cycle. The result registers take the new value on that same edge, so a read during the write-result cycle returns it.
- R5: Address 1 reads result bits 9:2. Address 2 reads result bits 1:0 in positions 7:6, and its other bits read 0.
- R6: `irq_o` sets on the edge where `busy_o` clears. It stays set, with no further writes, until software clears it.
- R7: Writing address 0 with bit 2 equal to 0 clears `irq_o`. Writing bit 2 as 1 does not set it. If a set and a clear fall in the same cycle, the set wins.
- R8: Address 0 bit 0 selects continuous mode. While it is set, `busy_o` and `sample_o` rise again on the first strobe edge after the write-result cycle. If the bit is cleared during a conversion, that conversion finishes and none follows.
- R9: A start write made while `busy_o` is high is ignored. The running conversion keeps its length and its result, and no conversion is queued behind it.
- R10: After reset `busy_o`, `sample_o` and `irq_o` are 0, `dac_code` is 0, and all three registers read 0.
- R11: Address 0 reads bit 0 as the continuous-mode bit, bit 1 as busy and bit 2 as the interrupt flag. Bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_stb | input | 1 | Machine-cycle strobe; the sequence advances only on edges where this is high |
| wr_en | input | 1 | Register write enable for one clock |
| addr | input | 2 | Register address: 0 control, 1 result high, 2 result low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at `addr` (combinational) |
| cmp_in | input | 1 | Comparator decision: 1 when the analog input is at or above `dac_code` |
| dac_code | output | 10 | Trial code driven to the capacitor array |
| sample_o | output | 1 | High during the sample phase |
| busy_o | output | 1 | Busy flag |
| irq_o | output | 1 | Interrupt-request flag |

## Verification
The hardest cases to reach from the ports are bus writes that land in the middle of a conversion. One is a repeated start, which must not extend the conversion or queue another. The other is clearing the continuous-mode bit while a conversion runs, which must let that conversion finish and then stop. The bench counts strobe edges from each start and injects these writes at a chosen strobe offset inside the conversion phase. It then checks, at every strobe edge, that the busy and sample waveforms and the result are unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_WRES   = 2'd3
  } phase_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_RHI  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_RLO  = 2'd2;

  localparam int CTRL_CONT = 0;
  localparam int CTRL_BUSY = 1;
  localparam int CTRL_IRQ  = 2;

  localparam int SAR_MAX_W = 16;

  // One approximation step: drop the bit under test unless the comparator
  // keeps it, then place the next lower trial bit.
  function automatic logic [SAR_MAX_W-1:0] sar_next(
    input logic [SAR_MAX_W-1:0] trial,
    input logic [SAR_MAX_W-1:0] mask,
    input logic                 keep
  );
    logic [SAR_MAX_W-1:0] t;
    t = keep ? trial : (trial & ~mask);
    return t | (mask >> 1);
  endfunction

endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic             last_bit,
  output logic [RES_W-1:0] result_d
);

  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] mask_q;

  assign result_d = RES_W'(sar_next(SAR_MAX_W'(trial_q), SAR_MAX_W'(mask_q), cmp_in));
  assign last_bit = mask_q[0];
  assign trial    = trial_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load) begin
      trial_q <= MSB;
      mask_q  <= MSB;
    end else if (step) begin
      trial_q <= result_d;
      mask_q  <= mask_q >> 1;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mc_stb,
  input  logic   start_req,
  input  logic   cont,
  input  logic   conv_last,
  output phase_e phase,
  output logic   sar_load,
  output logic   sar_step,
  output logic   wres_enter,
  output logic   start_take
);

  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ph_d       = ph_q;
    sar_load   = 1'b0;
    sar_step   = 1'b0;
    wres_enter = 1'b0;
    start_take = 1'b0;
    if (mc_stb) begin
      unique case (ph_q)
        PH_IDLE: if (start_req) begin
          ph_d       = PH_SAMPLE;
          start_take = 1'b1;
        end
        PH_SAMPLE: if (cnt_q == CNT_LAST) begin
          ph_d     = PH_CONV;
          sar_load = 1'b1;
        end
        PH_CONV: begin
          sar_step = 1'b1;
          if (conv_last) begin
            ph_d       = PH_WRES;
            wres_enter = 1'b1;
          end
        end
        PH_WRES: begin
          if (cont || start_req) begin
            ph_d       = PH_SAMPLE;
            start_take = 1'b1;
          end else begin
            ph_d = PH_IDLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (start_take)
        cnt_q <= '0;
      else if (mc_stb && ph_q == PH_SAMPLE)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              wres_enter,
  input  logic              start_take,
  input  logic [RES_W-1:0]  result_d,
  output logic [7:0]        rdata,
  output logic              cont,
  output logic              start_req,
  output logic              irq
);

  localparam int LOW_W = RES_W - 8;

  logic [RES_W-1:0] res_q;
  logic             wr_ctrl, wr_go;
  logic [7:0]       lo_view;

  assign wr_ctrl = wr_en && (addr == REG_CTRL);
  assign wr_go   = wr_en && (addr == REG_RLO);
  assign lo_view = 8'(res_q[LOW_W-1:0]) << (8 - LOW_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      cont      <= 1'b0;
      start_req <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wres_enter) res_q <= result_d;
      if (wr_ctrl) cont <= wdata[CTRL_CONT];
      if (start_take)
        start_req <= 1'b0;
      else if (wr_go && !busy)
        start_req <= 1'b1;
      if (wres_enter)
        irq <= 1'b1;
      else if (wr_ctrl && !wdata[CTRL_IRQ])
        irq <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = {5'b0, irq, busy, cont};
      REG_RHI:  rdata = res_q[RES_W-1 -: 8];
      REG_RLO:  rdata = lo_view;
      default:  rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_stb,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_o,
  output logic             busy_o,
  output logic             irq_o
);

  phase_e           phase;
  logic             sar_load, sar_step, wres_evt, start_take;
  logic             conv_last, cont, start_req;
  logic [RES_W-1:0] result_d;

  assign busy_o   = (phase == PH_SAMPLE) || (phase == PH_CONV);
  assign sample_o = (phase == PH_SAMPLE);

  adc_seq_fsm #(.SAMPLE_CYC(SAMPLE_CYC)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_stb     (mc_stb),
    .start_req  (start_req),
    .cont       (cont),
    .conv_last  (conv_last),
    .phase      (phase),
    .sar_load   (sar_load),
    .sar_step   (sar_step),
    .wres_enter (wres_evt),
    .start_take (start_take)
  );

  adc_sar_core #(.RES_W(RES_W)) sar_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sar_load),
    .step     (sar_step),
    .cmp_in   (cmp_in),
    .trial    (dac_code),
    .last_bit (conv_last),
    .result_d (result_d)
  );

  adc_seq_regs #(.RES_W(RES_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .busy       (busy_o),
    .wres_enter (wres_evt),
    .start_take (start_take),
    .result_d   (result_d),
    .rdata      (rdata),
    .cont       (cont),
    .start_req  (start_req),
    .irq        (irq_o)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mc_stb,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       busy_o,
  input logic       sample_o,
  input logic       irq_o,
  input logic       wres_evt
);

  // R3
  busy_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mc_stb) |-> $stable(busy_o));

  // R3
  sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o);

  // R1
  start_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sample_o);

  // R4
  busy_end_wres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(wres_evt));

  // R6
  irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o);

  // R7
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wres_evt |=> irq_o);

  // R7
  irq_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_en && addr == 2'd0 && !wdata[2]));

endmodule

bind adc_seq_ctrl adc_seq_chk chk_i (.*);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

  localparam int CLK_P   = 10;
  localparam int RES_W   = 10;
  localparam int S       = 2;
  localparam int STB_DIV = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mc_stb = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [7:0]       wdata = 8'd0;
  logic [7:0]       rdata;
  logic             cmp_in;
  logic [RES_W-1:0] dac_code;
  logic             sample_o, busy_o, irq_o;
  int               vin = 0;
  int               ph = 0;
  int               n_chk = 0;
  int               n_err = 0;

  adc_seq_ctrl #(.RES_W(RES_W), .SAMPLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_in(cmp_in), .dac_code(dac_code),
    .sample_o(sample_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    ph     <= (ph + 1) % STB_DIV;
    mc_stb <= (ph == STB_DIV - 1);
  end

  // ideal comparator model: input at or above trial code
  assign cmp_in = (vin >= int'(dac_code));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_stb();
    do @(posedge clk); while (!mc_stb);
    @(negedge clk);
  endtask

  // One conversion with edge-by-edge checks. inj_at >= 0 injects a bus
  // write at that conversion-phase strobe offset.
  task automatic run_conv(input int v, input bit do_start, input bit cont_on,
                          input int inj_at, input logic [1:0] inj_a,
                          input logic [7:0] inj_d);
    int rv;
    vin = v;
    if (do_start) bus_wr(2'd2, 8'h5A ^ v[7:0]);
    wait_stb();
    chk("R1", "busy at first strobe", int'(busy_o), 1);
    chk("R1", "sample at first strobe", int'(sample_o), 1);
    bus_rd(2'd0, rv);
    chk("R11", "ctrl busy/cont", rv & 3, 2 | int'(cont_on));
    for (int e = 1; e < S; e++) begin
      wait_stb();
      chk("R3", "sample held", int'(sample_o), 1);
    end
    for (int k = 0; k < RES_W; k++) begin
      wait_stb();
      chk("R3", "busy in conversion", int'(busy_o), 1);
      chk("R3", "sample off in conversion", int'(sample_o), 0);
      if (k == inj_at) begin
        addr = inj_a; wdata = inj_d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    wait_stb();
    chk("R4", "busy cleared at write-result", int'(busy_o), 0);
    chk("R6", "irq set at done", int'(irq_o), 1);
    bus_rd(2'd1, rv);
    chk("R2", "result high", rv, v >> 2);
    bus_rd(2'd2, rv);
    chk("R5", "result low", rv, (v & 3) << 6);
  endtask

  initial begin
    int rv;
    repeat (5) @(negedge clk);
    chk("R10", "busy reset", int'(busy_o), 0);
    chk("R10", "sample reset", int'(sample_o), 0);
    chk("R10", "irq reset", int'(irq_o), 0);
    chk("R10", "dac reset", int'(dac_code), 0);
    for (int a = 0; a < 3; a++) begin
      bus_rd(2'(a), rv);
      chk("R10", "register reset", rv, 0);
    end
    rst_n = 1'b1;
    repeat (4) wait_stb();
    chk("R1", "no start without write", int'(busy_o), 0);

    // exhaustive single-shot sweep
    for (int v = 0; v < (1 << RES_W); v++) begin
      run_conv(v, 1'b1, 1'b0, -1, 2'd0, 8'd0);
      wait_stb();
      chk("R8", "single mode stays idle", int'(busy_o), 0);
      if (v % 97 == 0) begin
        repeat (3) wait_stb();
        chk("R6", "irq held", int'(irq_o), 1);
        bus_wr(2'd0, 8'h04);
        chk("R7", "write of 1 keeps irq", int'(irq_o), 1);
        bus_rd(2'd0, rv);
        chk("R11", "ctrl irq bit", rv, 8'h04);
      end
      bus_wr(2'd0, 8'h00);
      chk("R7", "irq cleared by write", int'(irq_o), 0);
    end

    bus_wr(2'd0, 8'h04);
    chk("R7", "write of 1 does not set irq", int'(irq_o), 0);
    bus_wr(2'd0, 8'h00);

    // start write while busy must be ignored
    run_conv(600, 1'b1, 1'b0, 3, 2'd2, 8'hFF);
    repeat (3) begin
      wait_stb();
      chk("R9", "no queued start", int'(busy_o), 0);
    end
    bus_wr(2'd0, 8'h00);

    // continuous mode, then stop mid-conversion
    bus_wr(2'd0, 8'h01);
    run_conv(300, 1'b1, 1'b1, -1, 2'd0, 8'd0);
    run_conv(777, 1'b0, 1'b1, -1, 2'd0, 8'd0);
    run_conv(1023, 1'b0, 1'b1, -1, 2'd0, 8'd0);
    run_conv(45, 1'b0, 1'b1, 4, 2'd0, 8'h00);
    wait_stb();
    chk("R8", "stops after cont cleared", int'(busy_o), 0);
    repeat (2) wait_stb();
    chk("R8", "stays idle", int'(busy_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule